// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small, fully associative translation cache that sits between an address-generation stage and an external page walker. Each resident translation is labelled with a 12-bit address-space context. A change of the page-directory base image therefore does not have to discard translations that belong to other address spaces. A lookup presents a 48-bit linear address and receives, one cycle later, a hit flag, the physical address with the page offset merged in, and the page size. On a miss the walker resolves the translation and writes it back through the fill port.

Two control images are written through a small port: the base-register image and the feature-register image. Context tagging is switched on by one bit of the feature image. While tagging is on, the current context is the low 12 bits of the base image. While it is off, the current context is zero, and every write to the base image empties the cache. A separate command invalidates only the entries of one chosen context.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, both control images are zero and `rsp_valid` is low. Any lookup made then returns a miss.
- R2: A lookup presented in cycle N is answered in cycle N+1. `rsp_valid` is high in exactly the cycles that follow a cycle with `lk_valid` high. On a hit, `rsp_paddr` carries the translated address.
- R3: `fill_size` and `rsp_size` use the codes 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB. The compare ignores linear bits 11:0, 20:0 or 29:0 by size. The same low bits of the lookup address pass straight into `rsp_paddr`, and the remaining bits come from the stored frame.
- R4: With `cr_sel`=1, a write sets tagging from `cr_data[17]`. With `cr_sel`=0, a write sets the base image. The current context is `cr_data[11:0]` of the last base write while tagging is on, and zero while tagging is off, whatever the base image holds.
- R5: A fill is tagged with the context current in its cycle. A lookup hits only a valid entry whose tag equals the current context.
- R6: A base-image write made while tagging is off invalidates every entry. Made while tagging is on, it keeps all entries.
- R7: A flush command invalidates exactly the entries tagged with `flush_ctx`, and a lookup in the next cycle already misses them. Entries of other contexts stay valid.
- R8: A fill goes to the lowest-numbered invalid entry when one exists. With all entries valid, fills replace entries in round-robin order, starting from entry 0 after reset.
- R9: A lookup in the same cycle as a fill sees the cache state from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Lookup linear address |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_size | output | 2 | Page size code of the hit entry |
| fill_valid | input | 1 | Fill from the walker |
| fill_vaddr | input | 48 | Linear address of the filled page |
| fill_paddr | input | 52 | Physical address of the filled page |
| fill_size | input | 2 | Page size code of the fill |
| cr_wr | input | 1 | Control image write |
| cr_sel | input | 1 | 0 = base image, 1 = feature image |
| cr_data | input | 64 | Control image write data |
| flush_valid | input | 1 | Flush-by-context command |
| flush_ctx | input | 12 | Context to flush |

## Verification
The bench builds the block with its default parameters: 16 entries, 12-bit contexts, 48-bit linear and 52-bit physical addresses. With only 16 entries, a short run of fills fills the cache completely. The round-robin wrap of R8 and the point where an invalid entry stops being available can then be driven directly. The 52-bit physical width lets the bench check frames above 4 GiB, and the three size codes make the offset merge visible at each boundary.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  // Number of page-offset bits for a size code; reserved code acts as 4 KiB.
  function automatic int unsigned off_bits(input logic [1:0] sz);
    case (sz)
      2'd1:    off_bits = 21;
      2'd2:    off_bits = 30;
      default: off_bits = 12;
    endcase
  endfunction

  // Mask with ones over the page-offset bits.
  function automatic logic [63:0] off_mask(input logic [1:0] sz);
    off_mask = (64'd1 << off_bits(sz)) - 64'd1;
  endfunction

endpackage

// File: rtl/ctx_tlb_ctrl.sv
module ctx_tlb_ctrl #(
  parameter int CR_W   = 64,
  parameter int CTX_W  = 12,
  parameter int EN_BIT = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cr_wr,
  input  logic             cr_sel,
  input  logic [CR_W-1:0]  cr_data,
  output logic [CTX_W-1:0] cur_ctx,
  output logic             tag_en,
  output logic             flush_all
);

  logic [CTX_W-1:0] base_q, base_d;
  logic             en_q, en_d;
  logic             unused_cr;

  // Only the context field and the enable bit have an effect.
  assign unused_cr = ^cr_data;

  always_comb begin
    base_d = base_q;
    en_d   = en_q;
    if (cr_wr) begin
      if (cr_sel) en_d   = cr_data[EN_BIT];
      else        base_d = cr_data[CTX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      en_q   <= en_d;
    end
  end

  assign tag_en    = en_q;
  assign cur_ctx   = en_q ? base_q : '0;
  assign flush_all = cr_wr && !cr_sel && !en_q;

endmodule

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
  parameter int ENTRIES = 16,
  parameter int LA_W    = 48,
  parameter int PA_W    = 52,
  parameter int CTX_W   = 12
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [CTX_W-1:0]   ctx_i  [ENTRIES],
  input  logic [LA_W-1:0]    va_i   [ENTRIES],
  input  logic [PA_W-1:0]    pa_i   [ENTRIES],
  input  logic [1:0]         size_i [ENTRIES],
  input  logic [CTX_W-1:0]   cur_ctx,
  input  logic [LA_W-1:0]    lk_addr,
  output logic               hit,
  output logic [PA_W-1:0]    hit_pa,
  output logic [1:0]         hit_size
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [LA_W-1:0] lmask;
    assign lmask = LA_W'(ctx_tlb_pkg::off_mask(size_i[g]));
    assign match_vec[g] = valid_i[g] && (ctx_i[g] == cur_ctx) &&
                          (((lk_addr ^ va_i[g]) & ~lmask) == '0);
  end

  logic [PA_W-1:0] sel_pa;
  logic [1:0]      sel_size;
  logic [PA_W-1:0] pmask;

  // Lowest-numbered matching entry wins.
  always_comb begin
    sel_pa   = '0;
    sel_size = 2'd0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel_pa   = pa_i[i];
        sel_size = size_i[i];
      end
    end
  end

  assign pmask    = PA_W'(ctx_tlb_pkg::off_mask(sel_size));
  assign hit      = |match_vec;
  assign hit_size = sel_size;
  assign hit_pa   = (sel_pa & ~pmask) | (PA_W'(lk_addr) & pmask);

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               fill_i,
  output logic [IDX_W-1:0]   victim
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] first_free;
  logic             any_free;

  always_comb begin
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) first_free = IDX_W'(i);
    end
  end

  assign any_free = ~&valid_i;
  assign victim   = any_free ? first_free : ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_i && !any_free) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES = 16,
  parameter int LA_W    = 48,
  parameter int PA_W    = 52,
  parameter int CTX_W   = 12,
  parameter int CR_W    = 64,
  parameter int EN_BIT  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [LA_W-1:0]  lk_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_size,
  input  logic             fill_valid,
  input  logic [LA_W-1:0]  fill_vaddr,
  input  logic [PA_W-1:0]  fill_paddr,
  input  logic [1:0]       fill_size,
  input  logic             cr_wr,
  input  logic             cr_sel,
  input  logic [CR_W-1:0]  cr_data,
  input  logic             flush_valid,
  input  logic [CTX_W-1:0] flush_ctx
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [CTX_W-1:0] cur_ctx;
  logic             tag_en;
  logic             flush_all;

  ctx_tlb_ctrl #(.CR_W(CR_W), .CTX_W(CTX_W), .EN_BIT(EN_BIT)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cr_wr     (cr_wr),
    .cr_sel    (cr_sel),
    .cr_data   (cr_data),
    .cur_ctx   (cur_ctx),
    .tag_en    (tag_en),
    .flush_all (flush_all)
  );

  // Entry storage
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [LA_W-1:0]    va_q   [ENTRIES];
  logic [PA_W-1:0]    pa_q   [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [ENTRIES-1:0] we;
  logic [IDX_W-1:0]   victim;

  ctx_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) victim_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_q),
    .fill_i  (fill_valid),
    .victim  (victim)
  );

  // Fill data aligned to its page
  logic [LA_W-1:0] fill_va_m;
  logic [PA_W-1:0] fill_pa_m;
  assign fill_va_m = fill_vaddr & ~LA_W'(ctx_tlb_pkg::off_mask(fill_size));
  assign fill_pa_m = fill_paddr & ~PA_W'(ctx_tlb_pkg::off_mask(fill_size));

  always_comb begin
    valid_d = valid_q;
    we      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (flush_all) valid_d[i] = 1'b0;
      if (flush_valid && (ctx_q[i] == flush_ctx)) valid_d[i] = 1'b0;
      if (fill_valid && (victim == IDX_W'(i))) begin
        we[i]      = 1'b1;
        valid_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we[g]) begin
        ctx_q[g]  <= cur_ctx;
        va_q[g]   <= fill_va_m;
        pa_q[g]   <= fill_pa_m;
        size_q[g] <= fill_size;
      end
    end
  end

  // Lookup on pre-update state
  logic            m_hit;
  logic [PA_W-1:0] m_pa;
  logic [1:0]      m_size;

  ctx_tlb_match #(.ENTRIES(ENTRIES), .LA_W(LA_W), .PA_W(PA_W), .CTX_W(CTX_W)) match_i (
    .valid_i  (valid_q),
    .ctx_i    (ctx_q),
    .va_i     (va_q),
    .pa_i     (pa_q),
    .size_i   (size_q),
    .cur_ctx  (cur_ctx),
    .lk_addr  (lk_addr),
    .hit      (m_hit),
    .hit_pa   (m_pa),
    .hit_size (m_size)
  );

  // Registered answer
  logic            rv_q, rv_d, rh_q, rh_d;
  logic [PA_W-1:0] rpa_q;
  logic [1:0]      rsz_q;

  always_comb begin
    rv_d = lk_valid;
    rh_d = lk_valid && m_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      rh_q <= rh_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      rpa_q <= m_pa;
      rsz_q <= m_size;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_paddr = rpa_q;
  assign rsp_size  = rsz_q;

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [1:0]         rsp_size,
  input logic               cr_wr,
  input logic               cr_sel,
  input logic               fill_valid,
  input logic               flush_valid,
  input logic [CTX_W-1:0]   flush_ctx,
  input logic [ENTRIES-1:0] valid_q,
  input logic [CTX_W-1:0]   ctx_q [ENTRIES],
  input logic               tag_en,
  input logic [CTX_W-1:0]   cur_ctx
);

  logic [ENTRIES-1:0] fl_match;
  logic [$clog2(ENTRIES+1)-1:0] nvalid;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) fl_match[i] = (ctx_q[i] == flush_ctx);
    nvalid = $clog2(ENTRIES+1)'($countones(valid_q));
  end

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R3
  hit_size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && rsp_size != 2'd3));
  // R4
  ctx_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_en |-> (cur_ctx == '0));
  // R6
  base_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr && !cr_sel && !tag_en && !fill_valid) |=> (valid_q == '0));
  // R7
  flush_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !fill_valid) |=> ((valid_q & $past(fl_match)) == '0));
  // R8
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(&valid_q) && !flush_valid && !cr_wr) |=>
      (nvalid == $past(nvalid) + 1'b1));

endmodule

bind ctx_tlb ctx_tlb_chk #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_size    (rsp_size),
  .cr_wr       (cr_wr),
  .cr_sel      (cr_sel),
  .fill_valid  (fill_valid),
  .flush_valid (flush_valid),
  .flush_ctx   (flush_ctx),
  .valid_q     (valid_q),
  .ctx_q       (ctx_q),
  .tag_en      (tag_en),
  .cur_ctx     (cur_ctx)
);

// File: tb/ctx_tlb_tb_top.sv
module ctx_tlb_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [47:0] lk_addr;
  logic        rsp_valid, rsp_hit;
  logic [51:0] rsp_paddr;
  logic [1:0]  rsp_size;
  logic        fill_valid;
  logic [47:0] fill_vaddr;
  logic [51:0] fill_paddr;
  logic [1:0]  fill_size;
  logic        cr_wr, cr_sel;
  logic [63:0] cr_data;
  logic        flush_valid;
  logic [11:0] flush_ctx;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ctx_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_size(rsp_size),
    .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr), .fill_size(fill_size),
    .cr_wr(cr_wr), .cr_sel(cr_sel), .cr_data(cr_data),
    .flush_valid(flush_valid), .flush_ctx(flush_ctx)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [47:0] a, output logic h, output logic [51:0] pa,
                        output logic [1:0] sz);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    h = rsp_hit; pa = rsp_paddr; sz = rsp_size;
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R2: actual rsp_valid=0 expected=1");
    end
  endtask

  task automatic expect_hit(input string tag, input logic [47:0] a, input logic [51:0] epa,
                            input logic [1:0] esz);
    logic h; logic [51:0] pa; logic [1:0] sz;
    lookup(a, h, pa, sz);
    chk(tag, {h, sz, pa}, {1'b1, esz, epa});
  endtask

  task automatic expect_miss(input string tag, input logic [47:0] a);
    logic h; logic [51:0] pa; logic [1:0] sz;
    lookup(a, h, pa, sz);
    chk(tag, 64'(h), 64'd0);
  endtask

  task automatic do_fill(input logic [47:0] va, input logic [51:0] pa, input logic [1:0] sz);
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic cr_write(input logic sel, input logic [63:0] d);
    @(negedge clk);
    cr_wr = 1'b1; cr_sel = sel; cr_data = d;
    @(negedge clk);
    cr_wr = 1'b0;
  endtask

  task automatic flush(input logic [11:0] c);
    @(negedge clk);
    flush_valid = 1'b1; flush_ctx = c;
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  // R1
  task automatic t_reset;
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    expect_miss("R1 lookup after reset", 48'h0);
    @(negedge clk);
    chk("R2 rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  // R3 R2
  task automatic t_sizes;
    do_fill(48'h0000_1234_5000, 52'h0_0000_ABCD_E000, 2'd0);
    do_fill(48'h0000_4060_0000, 52'h0_0001_2340_0000, 2'd1);
    do_fill(48'h0080_0000_0000, 52'h0_0010_C000_0000, 2'd2);
    expect_hit("R3 4K page", 48'h0000_1234_5ABC, 52'h0_0000_ABCD_EABC, 2'd0);
    expect_hit("R3 2M page", 48'h0000_4061_2345, 52'h0_0001_2341_2345, 2'd1);
    expect_hit("R3 1G page", 48'h0080_1234_5678, 52'h0_0010_D234_5678, 2'd2);
    expect_miss("R3 4K neighbour", 48'h0000_1234_6000);
  endtask

  // R5 R6
  task automatic t_ctx;
    cr_write(1'b1, 64'h2_0000);
    cr_write(1'b0, 64'h005);
    expect_miss("R5 ctx0 entry under ctx5", 48'h0000_1234_5000);
    do_fill(48'h0000_5000_0000, 52'h0_0000_7000_0000, 2'd0);
    expect_hit("R5 ctx5 entry", 48'h0000_5000_0010, 52'h0_0000_7000_0010, 2'd0);
    cr_write(1'b0, 64'h007);
    expect_miss("R5 ctx5 entry under ctx7", 48'h0000_5000_0000);
    cr_write(1'b0, 64'h005);
    expect_hit("R6 kept across base write", 48'h0000_5000_0000, 52'h0_0000_7000_0000, 2'd0);
  endtask

  // R7
  task automatic t_flush;
    flush(12'h005);
    expect_miss("R7 flushed ctx", 48'h0000_5000_0000);
    cr_write(1'b0, 64'h000);
    expect_hit("R7 other ctx kept", 48'h0000_1234_5000, 52'h0_0000_ABCD_E000, 2'd0);
  endtask

  // R6 R4
  task automatic t_disable;
    cr_write(1'b1, 64'h0);
    expect_hit("R6 ctx0 before clear", 48'h0000_4060_0000, 52'h0_0001_2340_0000, 2'd1);
    cr_write(1'b0, 64'h123);
    expect_miss("R6 base write clears", 48'h0000_4060_0000);
    do_fill(48'h0000_6000_0000, 52'h0_0000_9000_0000, 2'd0);
    expect_hit("R4 ctx zero while off", 48'h0000_6000_0000, 52'h0_0000_9000_0000, 2'd0);
    cr_write(1'b1, 64'h2_0000);
    expect_miss("R4 ctx from base when on", 48'h0000_6000_0000);
    cr_write(1'b1, 64'h0);
    cr_write(1'b0, 64'h0);
  endtask

  // R8
  task automatic t_replace;
    for (int i = 0; i < 16; i++)
      do_fill(48'(i) << 12, (52'(i) + 52'h100) << 12, 2'd0);
    expect_hit("R8 entry 0 resident", 48'h0, 52'h100 << 12, 2'd0);
    expect_hit("R8 entry 15 resident", 48'hF000, 52'h10F << 12, 2'd0);
    do_fill(48'h100 << 12, 52'h900 << 12, 2'd0);
    expect_miss("R8 first replace evicts 0", 48'h0);
    expect_hit("R8 new entry", 48'h100 << 12, 52'h900 << 12, 2'd0);
    expect_hit("R8 entry 1 still", 48'h1000, 52'h101 << 12, 2'd0);
    do_fill(48'h200 << 12, 52'hA00 << 12, 2'd0);
    expect_miss("R8 second replace evicts 1", 48'h1000);
    expect_hit("R8 entry 2 still", 48'h2000, 52'h102 << 12, 2'd0);
  endtask

  // R9
  task automatic t_same_cycle;
    cr_write(1'b0, 64'h0);
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = 48'h0000_7700_0000;
    fill_paddr = 52'h0_0000_3300_0000; fill_size = 2'd0;
    lk_valid = 1'b1; lk_addr = 48'h0000_7700_0000;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk("R9 lookup sees pre-fill", {62'd0, rsp_valid, rsp_hit}, 64'd2);
    expect_hit("R9 hit after fill", 48'h0000_7700_0044, 52'h0_0000_3300_0044, 2'd0);
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0;
    fill_valid = 1'b0; fill_vaddr = '0; fill_paddr = '0; fill_size = '0;
    cr_wr = 1'b0; cr_sel = 1'b0; cr_data = '0;
    flush_valid = 1'b0; flush_ctx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_ctx();
    t_flush();
    t_disable();
    t_replace();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule